// File: doc/BRIEF.md
# Pipelined Synchronous Byte-Write Memory Core

This block models a single-port synchronous memory with registered inputs and a registered read output. By default it holds 1,024 words, and `ADDR_W` = 15 gives the full 32,768-word array. Each word is split into byte lanes. Each lane carries eight data bits plus a parity bit that is stored like any other bit. The shared data path is split into a write-data input, a read-data output and an output-drive qualifier. A board-level tri-state buffer would use that qualifier.

An access is opened by one of two address strobes while the three chip selects are all active. The processor strobe always starts a read. The controller strobe starts a read or a single-cycle write, chosen by the write controls. After an access has opened a session, cycles with no strobe continue the burst. The next address comes from an external sequencer on the address pins when the step input is low. The last address is repeated when the step input is high. A strobe seen while the chip selects are inactive closes the session.

Read data leaves through an output register. Any detected write blanks the output drive whatever the output-enable pin says. The output-enable pin blanks the drive combinationally.

Top module: `ssr_core`

## Requirements
- R1: While reset is low, and after it is released until the first read reaches the output, `rdata_drive` is 0.
- R2: With `write_all_n` low, a write stores all four lanes of `wdata`, whatever `byte_wr_en_n` and `lane_sel_n` are.
- R3: With `write_all_n` high and `byte_wr_en_n` low, only the lanes whose `lane_sel_n` bit is 0 are written. The other lanes keep their contents.
- R4: A cycle is a write only if `write_all_n` is low, or `byte_wr_en_n` is low with at least one `lane_sel_n` bit low. Any other combination makes it a read.
- R5: `strobe_ctl_n` low with `strobe_proc_n` high and all chip selects active (`cs1_n`=0, `cs2`=1, `cs3_n`=0) starts an access at `addr`. It is a write completed in that one cycle, or a read if no write combination is present.
- R6: `strobe_proc_n` low with the chip selects active starts a read at `addr`. The write controls are ignored in that cycle, even when `strobe_ctl_n` is also low.
- R7: A read whose controls are sampled at rising edge k puts its word on `rdata`, with `rdata_drive` high if `out_en_n` is low, from edge k+1 until edge k+2.
- R8: In an open session, a cycle with both strobes high is a continuation. It uses `addr` when `burst_step_n` is 0 and repeats the previous access address when `burst_step_n` is 1. Its write controls are sampled as in R4.
- R9: In the cycle after a write is sampled, `rdata_drive` is 0 even with `out_en_n` low.
- R10: `out_en_n` high forces `rdata_drive` to 0 at once, without waiting for a clock edge.
- R11: A strobe sampled while any chip select is inactive closes the session. `rdata_drive` is 0 after the second edge following it. Later strobe-free cycles make no access, so any writes in them are lost.
- R12: Lane i occupies `wdata`/`rdata` bits [9i+8:9i], its parity bit is bit 9i+8, and `lane_sel_n[i]` selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| addr | input | ADDR_W | Word address |
| strobe_proc_n | input | 1 | Processor address strobe, active low, starts a read |
| strobe_ctl_n | input | 1 | Controller address strobe, active low, starts a read or write |
| burst_step_n | input | 1 | Low: continuation takes `addr`; high: repeat last address |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| write_all_n | input | 1 | Global write, active low, all lanes |
| byte_wr_en_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| wdata | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_drive | output | 1 | High when `rdata` should be driven onto the shared bus |

## Verification
The bench builds the core with `ADDR_W` = 6 and keeps the default four 9-bit lanes. With only 64 words, random addresses hit each other often. Repeated writes and byte writes to the same word, and read-after-write in the next pipeline slot, occur hundreds of times within a few thousand cycles. The small depth also lets the bench initialise every word first, so every read has a defined expected value, including lanes a byte write leaves alone.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
    localparam int unsigned LANES_DEF  = 4;
    localparam int unsigned LANE_W_DEF = 9;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/ssr_access_decode.sv
// Decides what the current cycle does: which access kind, at which address,
// on which lanes, and whether the burst session stays open.
module ssr_access_decode
    import ssr_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = LANES_DEF
) (
    input  logic              strobe_proc_n,
    input  logic              strobe_ctl_n,
    input  logic              burst_step_n,
    input  logic              chip_sel,
    input  logic              write_all_n,
    input  logic              byte_wr_en_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sess_q,
    input  logic [ADDR_W-1:0] last_addr_q,
    output acc_kind_e         kind,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  lane_we,
    output logic              sess_d
);
    logic [LANES-1:0] wr_lanes;
    logic             any_wr;
    logic             started;

    always_comb begin
        if (!write_all_n) begin
            wr_lanes = '1;
        end else if (!byte_wr_en_n) begin
            wr_lanes = ~lane_sel_n;
        end else begin
            wr_lanes = '0;
        end
        any_wr  = |wr_lanes;
        started = !strobe_proc_n || !strobe_ctl_n;

        kind     = ACC_NONE;
        acc_addr = last_addr_q;
        lane_we  = '0;
        sess_d   = sess_q;

        if (started) begin
            sess_d = chip_sel;
            if (chip_sel) begin
                acc_addr = addr;
                if (!strobe_proc_n || !any_wr) begin
                    kind = ACC_READ;
                end else begin
                    kind    = ACC_WRITE;
                    lane_we = wr_lanes;
                end
            end
        end else if (sess_q) begin
            acc_addr = burst_step_n ? last_addr_q : addr;
            if (any_wr) begin
                kind    = ACC_WRITE;
                lane_we = wr_lanes;
            end else begin
                kind = ACC_READ;
            end
        end
    end
endmodule

// File: rtl/ssr_lane.sv
// One byte lane of the array: synchronous write, combinational read.
module ssr_lane #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANE_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [LANE_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ssr_core.sv
module ssr_core
    import ssr_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = LANES_DEF,
    parameter int unsigned LANE_W = LANE_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strobe_proc_n,
    input  logic                    strobe_ctl_n,
    input  logic                    burst_step_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    write_all_n,
    input  logic                    byte_wr_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    out_en_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drive
);
    localparam int unsigned DATA_W = LANES * LANE_W;

    typedef struct packed {
        acc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lane_we;
        logic [DATA_W-1:0] wdata;
    } stage_t;

    typedef struct packed {
        logic              sess;
        logic [ADDR_W-1:0] last_addr;
        stage_t            stg;
        logic              out_vld;
        logic [DATA_W-1:0] out_data;
    } state_t;

    state_t state_d, state_q;

    acc_kind_e         dec_kind;
    logic [ADDR_W-1:0] dec_addr;
    logic [LANES-1:0]  dec_we;
    logic              dec_sess;
    logic              chip_sel;
    logic [DATA_W-1:0] arr_rdata;

    assign chip_sel = !cs1_n && cs2 && !cs3_n;

    ssr_access_decode #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES)
    ) i_decode (
        .strobe_proc_n (strobe_proc_n),
        .strobe_ctl_n  (strobe_ctl_n),
        .burst_step_n  (burst_step_n),
        .chip_sel      (chip_sel),
        .write_all_n   (write_all_n),
        .byte_wr_en_n  (byte_wr_en_n),
        .lane_sel_n    (lane_sel_n),
        .addr          (addr),
        .sess_q        (state_q.sess),
        .last_addr_q   (state_q.last_addr),
        .kind          (dec_kind),
        .acc_addr      (dec_addr),
        .lane_we       (dec_we),
        .sess_d        (dec_sess)
    );

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        ssr_lane #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
        ) i_lane (
            .clk   (clk),
            .we    ((state_q.stg.kind == ACC_WRITE) && state_q.stg.lane_we[gi]),
            .waddr (state_q.stg.addr),
            .wdata (state_q.stg.wdata[gi*LANE_W +: LANE_W]),
            .raddr (state_q.stg.addr),
            .rdata (arr_rdata[gi*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        state_d           = state_q;
        state_d.sess      = dec_sess;
        state_d.stg.kind  = dec_kind;
        state_d.stg.addr  = dec_addr;
        state_d.stg.lane_we = dec_we;
        state_d.stg.wdata = wdata;
        if (dec_kind != ACC_NONE) begin
            state_d.last_addr = dec_addr;
        end
        state_d.out_vld = (state_q.stg.kind == ACC_READ);
        if (state_q.stg.kind == ACC_READ) begin
            state_d.out_data = arr_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata       = state_q.out_data;
    assign rdata_drive = state_q.out_vld && (state_q.stg.kind != ACC_WRITE) && !out_en_n;
endmodule

// File: rtl/ssr_core_chk.sv
module ssr_core_chk #(
    parameter int unsigned LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_proc_n,
    input logic             strobe_ctl_n,
    input logic             cs1_n,
    input logic             cs2,
    input logic             cs3_n,
    input logic             write_all_n,
    input logic             byte_wr_en_n,
    input logic [LANES-1:0] lane_sel_n,
    input logic             out_en_n,
    input logic             rdata_drive
);
    logic sel;
    logic strobe_seen;
    logic wr_combo;

    assign sel         = !cs1_n && cs2 && !cs3_n;
    assign strobe_seen = !strobe_proc_n || !strobe_ctl_n;
    assign wr_combo    = !write_all_n || (!byte_wr_en_n && !(&lane_sel_n));

    // R9 (with R5): a controller-strobe write blanks the drive next cycle
    a_r9_write_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctl_n && strobe_proc_n && sel && wr_combo) |=> !rdata_drive);

    // R10
    a_r10_oe_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_drive);

    // R11
    a_r11_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_seen && !sel) |-> ##2 !rdata_drive);

    // R7 and R6: a processor-strobe start is a read that reaches the output
    a_r7_read_reaches_out: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_proc_n && sel) ##1 !wr_combo |-> ##1 (out_en_n || rdata_drive));
endmodule

bind ssr_core ssr_core_chk #(.LANES(LANES)) i_ssr_core_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe_proc_n (strobe_proc_n),
    .strobe_ctl_n  (strobe_ctl_n),
    .cs1_n         (cs1_n),
    .cs2           (cs2),
    .cs3_n         (cs3_n),
    .write_all_n   (write_all_n),
    .byte_wr_en_n  (byte_wr_en_n),
    .lane_sel_n    (lane_sel_n),
    .out_en_n      (out_en_n),
    .rdata_drive   (rdata_drive)
);

// File: tb/test_ssr_core.sv
module test_ssr_core;
    localparam int AW = 6;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          strobe_proc_n = 1'b1;
    logic          strobe_ctl_n = 1'b1;
    logic          burst_step_n = 1'b1;
    logic          cs1_n = 1'b1;
    logic          cs2 = 1'b0;
    logic          cs3_n = 1'b1;
    logic          write_all_n = 1'b1;
    logic          byte_wr_en_n = 1'b1;
    logic [LN-1:0] lane_sel_n = '1;
    logic [DW-1:0] wdata = '0;
    logic          out_en_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    always #4 clk = ~clk;

    ssr_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_ssr_core (
        .clk (clk), .rst_n (rst_n), .addr (addr),
        .strobe_proc_n (strobe_proc_n), .strobe_ctl_n (strobe_ctl_n),
        .burst_step_n (burst_step_n), .cs1_n (cs1_n), .cs2 (cs2), .cs3_n (cs3_n),
        .write_all_n (write_all_n), .byte_wr_en_n (byte_wr_en_n),
        .lane_sel_n (lane_sel_n), .wdata (wdata), .out_en_n (out_en_n),
        .rdata (rdata), .rdata_drive (rdata_drive)
    );

    typedef struct {
        bit            rd;
        bit            wr;
        logic [DW-1:0] data;
        string         tag;
    } ent_t;

    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 0;
    logic [DW-1:0] ref_mem [NW];
    ent_t          p1, p2;
    bit            sess = 0;
    int            last_a = 0;
    bit            oe_cur = 0;

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic [DW-1:0] rnd();
        return DW'({$urandom(), $urandom()});
    endfunction

    // One cycle: check what the previous cycles should show, then apply inputs
    // and update the reference model from the requirements.
    task automatic drive(string tag, bit p_n, bit c_n, bit adv_n, bit sel,
                         bit gw_n, bit bwe_n, bit [LN-1:0] bs_n, int a,
                         logic [DW-1:0] d, bit oe_n);
        bit            exp_oe;
        bit            start;
        bit            rd;
        bit            wr;
        int            acc_a;
        logic [LN-1:0] we;
        ent_t          e;
        @(negedge clk);
        exp_oe = !oe_cur && p2.rd && !p1.wr;
        chk(p1.wr ? "R9" : p2.tag, DW'(rdata_drive), DW'(exp_oe));
        if (exp_oe) chk(p2.tag, rdata, p2.data);

        strobe_proc_n = p_n;
        strobe_ctl_n  = c_n;
        burst_step_n  = adv_n;
        if (sel) begin
            cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
        end else begin
            case ($urandom_range(0, 2))
                0:       begin cs1_n = 1'b1; cs2 = 1'b1; cs3_n = 1'b0; end
                1:       begin cs1_n = 1'b0; cs2 = 1'b0; cs3_n = 1'b0; end
                default: begin cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b1; end
            endcase
        end
        write_all_n  = gw_n;
        byte_wr_en_n = bwe_n;
        lane_sel_n   = bs_n;
        addr         = AW'(a);
        wdata        = d;
        out_en_n     = oe_n;
        oe_cur       = oe_n;

        // R4: write decode
        we = !gw_n ? '1 : (!bwe_n ? ~bs_n : '0);
        start = !p_n || !c_n;
        rd = 0; wr = 0; acc_a = last_a;
        if (start) begin
            sess = sel;
            if (sel) begin
                acc_a = a;
                if (!p_n || we == '0) rd = 1; else wr = 1;
            end
        end else if (sess) begin
            acc_a = adv_n ? last_a : a;
            if (we != '0) wr = 1; else rd = 1;
        end
        if (rd || wr) last_a = acc_a;
        e.rd = rd; e.wr = wr; e.tag = tag; e.data = '0;
        if (rd) e.data = ref_mem[acc_a];
        if (wr) begin
            for (int i = 0; i < LN; i++) begin
                if (we[i]) ref_mem[acc_a][i*LW +: LW] = d[i*LW +: LW];
            end
        end
        p2 = p1;
        p1 = e;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'd5150));
        p1 = '{0, 0, '0, "R1"};
        p2 = '{0, 0, '0, "R1"};
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", DW'(rdata_drive), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", DW'(rdata_drive), '0);

        // Fill every word with controller-strobe global writes (R5, R2)
        for (int a = 0; a < NW; a++) drive("R5", 1, 0, 1, 1, 0, 1, 4'hF, a, rnd(), 0);

        // R2: global write ignores lane selects
        drive("R2", 1, 0, 1, 1, 0, 0, 4'hF, 3, rnd(), 0);
        drive("R2", 0, 1, 1, 1, 1, 1, 4'hF, 3, '0, 0);
        drive("R11", 1, 0, 1, 0, 1, 1, 4'hF, 0, '0, 0);
        // R3: byte write of lanes 0 and 2 only
        drive("R3", 1, 0, 1, 1, 1, 0, 4'b1010, 4, rnd(), 0);
        drive("R3", 0, 1, 1, 1, 1, 1, 4'hF, 4, '0, 0);
        // R12: lane 3 with its parity bit (bits 35:27)
        drive("R12", 1, 0, 1, 1, 1, 0, 4'b0111, 5, 36'hFF8000000, 0);
        drive("R12", 0, 1, 1, 1, 1, 1, 4'hF, 5, '0, 0);
        // R4: combinations that are not writes
        drive("R4", 1, 0, 1, 1, 1, 0, 4'hF, 6, rnd(), 0);
        drive("R4", 1, 0, 1, 1, 1, 1, 4'h0, 6, rnd(), 0);
        // R6: processor strobe ignores write controls
        drive("R6", 0, 1, 1, 1, 0, 0, 4'h0, 7, rnd(), 0);
        drive("R6", 0, 0, 1, 1, 0, 1, 4'hF, 7, rnd(), 0);
        drive("R6", 0, 1, 1, 1, 1, 1, 4'hF, 7, '0, 0);
        // R5: controller strobe with chip selects inactive writes nothing
        drive("R5", 1, 0, 1, 0, 0, 1, 4'hF, 9, rnd(), 0);
        drive("R5", 0, 1, 1, 1, 1, 1, 4'hF, 9, '0, 0);
        // R8: continuation, step and repeat
        drive("R8", 0, 1, 1, 1, 1, 1, 4'hF, 8, '0, 0);
        drive("R8", 1, 1, 0, 1, 1, 1, 4'hF, 9, '0, 0);
        drive("R8", 1, 1, 1, 1, 1, 1, 4'hF, 20, '0, 0);
        drive("R8", 1, 1, 0, 1, 0, 1, 4'hF, 10, rnd(), 0);
        drive("R8", 1, 1, 0, 1, 1, 1, 4'hF, 10, '0, 0);
        // R9: write right after a read with output enable low
        drive("R9", 0, 1, 1, 1, 1, 1, 4'hF, 11, '0, 0);
        drive("R9", 1, 0, 1, 1, 0, 1, 4'hF, 11, rnd(), 0);
        // R11: deselect, then strobe-free writes are lost
        drive("R11", 0, 1, 1, 0, 1, 1, 4'hF, 0, '0, 0);
        drive("R11", 1, 1, 0, 1, 0, 1, 4'hF, 12, rnd(), 0);
        drive("R11", 1, 1, 1, 1, 0, 1, 4'hF, 12, rnd(), 0);
        drive("R11", 0, 1, 1, 1, 1, 1, 4'hF, 12, '0, 0);
        // R7 and R10: read pipeline, then asynchronous output enable
        drive("R7", 0, 1, 1, 1, 1, 1, 4'hF, 13, '0, 0);
        drive("R7", 1, 1, 1, 1, 1, 1, 4'hF, 0, '0, 0);
        drive("R7", 1, 1, 1, 1, 1, 1, 4'hF, 0, '0, 0);
        #2;
        out_en_n = 1'b1;
        #1;
        chk("R10", DW'(rdata_drive), '0);
        out_en_n = 1'b0;
        #1;
        chk("R10", DW'(rdata_drive), DW'(1'b1));

        // Constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            int  kind = $urandom_range(0, 9);
            bit  p_n = !(kind <= 2);
            bit  c_n = !((kind >= 3 && kind <= 5) || (kind == 0 && $urandom_range(0, 1) == 1));
            bit  sel = ($urandom_range(0, 15) != 0);
            string tg = (kind <= 2) ? "R6" : ((kind <= 5) ? "R5" : "R8");
            drive(tg, p_n, c_n, 1'($urandom_range(0, 1)), sel,
                  ($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                  LN'($urandom_range(0, 15)), $urandom_range(0, NW - 1), rnd(),
                  ($urandom_range(0, 7) == 0));
        end
        drive("R11", 0, 1, 1, 0, 1, 1, 4'hF, 0, '0, 0);
        drive("R11", 1, 1, 1, 1, 1, 1, 4'hF, 0, '0, 0);
        drive("R11", 1, 1, 1, 1, 1, 1, 4'hF, 0, '0, 0);
        summary();
    end
endmodule